// File: doc/BRIEF.md
# Single-Flag Compare and Branch Unit

This unit holds one true/false status flag for a simple processor pipeline. Compare operations write the flag from a relation between two 32-bit register operands. The two conditional-branch operations read it to decide whether a branch is taken. Every other operation code, including add and subtract, passes through without touching the flag. Programs therefore build their branch conditions from compares only, and arithmetic placed between a compare and its branch leaves the condition intact.

The flag is a single register. A compare issued in one cycle updates it at the end of that cycle, so a branch issued in the following cycle already sees the new value. The branch-taken decision and the target address are combinational from the current operation, the flag register, the program counter and an 8-bit displacement. The pipeline can redirect fetch in the same cycle as the branch.

Top module: `cmp_branch_unit`

## Requirements
- R1: Synchronous active-low reset clears the flag to 0. While reset is held with operation code 0, the branch-taken output is 0.
- R2: Code 4 (signed greater-or-equal) sets the flag when operand A, read as two's complement, is at least operand B, and clears it otherwise.
- R3: Code 3 (equality) sets the flag when A equals B and clears it otherwise. This includes a compare of A against B = 0.
- R4: Codes 1 (add) and 2 (subtract) leave the flag unchanged and never assert branch-taken.
- R5: Code 9 (branch if true) asserts branch-taken in the same cycle exactly when the flag is 1.
- R6: Code 10 (branch if false) asserts branch-taken in the same cycle exactly when the flag is 0.
- R7: Code 5 (signed greater-than) sets the flag when A > B as two's complement values, and clears it otherwise.
- R8: Code 6 (unsigned higher-or-same) sets the flag when A >= B as unsigned values. Code 7 (unsigned higher) sets it when A > B unsigned. Each clears the flag otherwise.
- R9: Code 8 (positive-or-zero) sets the flag when A read as two's complement is >= 0. Operand B has no effect on the result.
- R10: The target output always equals PC + 4 + 2 × sign-extended 8-bit displacement, taken modulo 2^32.
- R11: A flag written by a compare in one cycle decides a branch issued in the very next cycle.
- R12: Code 0 and codes 11 to 15 never change the flag and never assert branch-taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Operation code of the current cycle |
| rs_a_i | input | 32 | First register operand |
| rs_b_i | input | 32 | Second register operand |
| pc_i | input | 32 | Program counter of the current operation |
| disp_i | input | 8 | Signed branch displacement, in units of 2 bytes |
| flag_o | output | 1 | Current status flag |
| br_taken_o | output | 1 | Conditional branch is taken this cycle |
| br_target_o | output | 32 | Branch target address |

## Verification
The flag is the unit's only state, and it is visible directly on flag_o one clock edge after the compare that wrote it. A wrong compare result, or a non-compare code that writes the flag, therefore shows up on the next cycle. A wrong flag also shows up on br_taken_o, in the same cycle as the next branch-if-true or branch-if-false. Back-to-back compare/branch pairs catch a flag that is delayed by a cycle. Operand pairs that differ only in sign or in unsigned order separate the signed and unsigned relations.

// File: rtl/cbu_pkg.sv
// Package: operation codes and decoded control shared by the compare/branch unit.
// Assumes a 4-bit operation code. Codes not listed are treated as "other".
package cbu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP    = 4'd0,
        OP_ADD    = 4'd1,
        OP_SUB    = 4'd2,
        OP_CMP_EQ = 4'd3,
        OP_CMP_GE = 4'd4,
        OP_CMP_GT = 4'd5,
        OP_CMP_HS = 4'd6,
        OP_CMP_HI = 4'd7,
        OP_CMP_PZ = 4'd8,
        OP_BR_T   = 4'd9,
        OP_BR_F   = 4'd10
    } cbu_op_e;

    typedef enum logic [2:0] {
        SEL_EQ = 3'd0,
        SEL_GE = 3'd1,
        SEL_GT = 3'd2,
        SEL_HS = 3'd3,
        SEL_HI = 3'd4,
        SEL_PZ = 3'd5
    } cmp_sel_e;

    typedef struct packed {
        logic     is_cmp;
        logic     is_bt;
        logic     is_bf;
        cmp_sel_e sel;
    } cbu_ctl_t;

endpackage

// File: rtl/cbu_decode.sv
// Module: cbu_decode
// Turns the raw operation code into control bits: whether the flag is written,
// which relation is selected, and which branch polarity applies.
// Assumes: any code outside the enumerated set decodes to "no effect".
module cbu_decode
    import cbu_pkg::*;
(
    input  logic [OP_W-1:0] op_i,
    output cbu_ctl_t        ctl_o
);

    // Decode operation code into control fields.
    always_comb begin
        ctl_o        = '0;
        ctl_o.sel    = SEL_EQ;
        case (cbu_op_e'(op_i))
            OP_CMP_EQ: begin ctl_o.is_cmp = 1'b1; ctl_o.sel = SEL_EQ; end
            OP_CMP_GE: begin ctl_o.is_cmp = 1'b1; ctl_o.sel = SEL_GE; end
            OP_CMP_GT: begin ctl_o.is_cmp = 1'b1; ctl_o.sel = SEL_GT; end
            OP_CMP_HS: begin ctl_o.is_cmp = 1'b1; ctl_o.sel = SEL_HS; end
            OP_CMP_HI: begin ctl_o.is_cmp = 1'b1; ctl_o.sel = SEL_HI; end
            OP_CMP_PZ: begin ctl_o.is_cmp = 1'b1; ctl_o.sel = SEL_PZ; end
            OP_BR_T:   ctl_o.is_bt = 1'b1;
            OP_BR_F:   ctl_o.is_bf = 1'b1;
            default:   ctl_o = ctl_o;
        endcase
    end

endmodule

// File: rtl/cbu_compare.sv
// Module: cbu_compare
// Evaluates the selected relation between two operands with one shared
// subtractor. Carry gives the unsigned order. Sign xor overflow gives the signed order.
// Assumes: operands are DATA_W bits; the result is meaningful only for compares.
module cbu_compare
    import cbu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  cmp_sel_e          sel_i,
    output logic              res_o
);

    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0] diff;
    logic            eq, no_borrow, ovf, s_lt;

    // Shared subtraction A - B with carry out (1 = no borrow).
    always_comb begin
        diff      = {1'b0, a_i} + {1'b0, ~b_i} + {{DATA_W{1'b0}}, 1'b1};
        no_borrow = diff[DATA_W];
        eq        = (a_i == b_i);
        ovf       = (a_i[MSB] != b_i[MSB]) && (diff[MSB] != a_i[MSB]);
        s_lt      = diff[MSB] ^ ovf;
    end

    // Pick the relation named by the selector.
    always_comb begin
        case (sel_i)
            SEL_EQ:  res_o = eq;
            SEL_GE:  res_o = ~s_lt;
            SEL_GT:  res_o = ~s_lt & ~eq;
            SEL_HS:  res_o = no_borrow;
            SEL_HI:  res_o = no_borrow & ~eq;
            SEL_PZ:  res_o = ~a_i[MSB];
            default: res_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/cbu_flag_reg.sv
// Module: cbu_flag_reg
// Holds the single status flag. Written only when a compare is decoded.
// Assumes synchronous active-low reset to 0.
module cbu_flag_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en_i,
    input  logic wr_val_i,
    output logic flag_o
);

    // Flag storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       flag_o <= 1'b0;
        else if (wr_en_i) flag_o <= wr_val_i;
    end

endmodule

// File: rtl/cbu_branch.sv
// Module: cbu_branch
// Forms the branch decision from the flag and the polarity bits, and the
// target as PC + PC_STEP + (sign-extended displacement << DISP_SHIFT).
// Assumes: address arithmetic wraps modulo 2^ADDR_W.
module cbu_branch #(
    parameter int ADDR_W     = 32,
    parameter int DISP_W     = 8,
    parameter int PC_STEP    = 4,
    parameter int DISP_SHIFT = 1
) (
    input  logic              flag_i,
    input  logic              is_bt_i,
    input  logic              is_bf_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic              taken_o,
    output logic [ADDR_W-1:0] target_o
);

    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] disp_ext, offset;

    // Taken decision for either polarity.
    always_comb taken_o = (is_bt_i & flag_i) | (is_bf_i & ~flag_i);

    // Target address arithmetic.
    always_comb begin
        disp_ext = {{EXT_W{disp_i[DISP_W-1]}}, disp_i};
        offset   = disp_ext << DISP_SHIFT;
        target_o = pc_i + ADDR_W'(PC_STEP) + offset;
    end

endmodule

// File: rtl/cmp_branch_unit.sv
// Module: cmp_branch_unit (top)
// Single-flag compare and branch unit: compares write the flag, branches read
// it, every other code leaves it alone. A compare is visible to the next cycle.
// Assumes one operation per cycle; register file and flush logic live elsewhere.
module cmp_branch_unit
    import cbu_pkg::*;
#(
    parameter int DATA_W     = 32,
    parameter int ADDR_W     = 32,
    parameter int DISP_W     = 8,
    parameter int PC_STEP    = 4,
    parameter int DISP_SHIFT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] rs_a_i,
    input  logic [DATA_W-1:0] rs_b_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [DISP_W-1:0] disp_i,
    output logic              flag_o,
    output logic              br_taken_o,
    output logic [ADDR_W-1:0] br_target_o
);

    cbu_ctl_t ctl;
    logic     cmp_res;

    cbu_decode u_decode (
        .op_i  (op_i),
        .ctl_o (ctl)
    );

    cbu_compare #(.DATA_W(DATA_W)) u_compare (
        .a_i   (rs_a_i),
        .b_i   (rs_b_i),
        .sel_i (ctl.sel),
        .res_o (cmp_res)
    );

    cbu_flag_reg u_flag (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (ctl.is_cmp),
        .wr_val_i (cmp_res),
        .flag_o   (flag_o)
    );

    cbu_branch #(
        .ADDR_W     (ADDR_W),
        .DISP_W     (DISP_W),
        .PC_STEP    (PC_STEP),
        .DISP_SHIFT (DISP_SHIFT)
    ) u_branch (
        .flag_i   (flag_o),
        .is_bt_i  (ctl.is_bt),
        .is_bf_i  (ctl.is_bf),
        .pc_i     (pc_i),
        .disp_i   (disp_i),
        .taken_o  (br_taken_o),
        .target_o (br_target_o)
    );

endmodule

// File: rtl/cbu_checker.sv
// Module: cbu_checker
// Temporal properties on the ports of cmp_branch_unit, bound to every instance.
module cbu_checker #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [3:0]        op_i,
    input logic [DATA_W-1:0] rs_a_i,
    input logic [DATA_W-1:0] rs_b_i,
    input logic              flag_o,
    input logic              br_taken_o
);

    logic writes_flag;
    always_comb writes_flag = (op_i >= 4'd3) && (op_i <= 4'd8);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> !flag_o);

    assert_ge_signed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd4) |=> flag_o == ($signed($past(rs_a_i)) >= $signed($past(rs_b_i))));

    assert_eq_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd3) |=> flag_o == ($past(rs_a_i) == $past(rs_b_i)));

    assert_hold_flag_R4_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !writes_flag |=> $stable(flag_o));

    assert_branch_true_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd9) |-> br_taken_o == flag_o);

    assert_branch_false_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd10) |-> br_taken_o == !flag_o);

    assert_no_taken_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 4'd9 && op_i != 4'd10) |-> !br_taken_o);

    assert_unsigned_hs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 4'd6) |=> flag_o == ($past(rs_a_i) >= $past(rs_b_i)));

endmodule

bind cmp_branch_unit cbu_checker #(.DATA_W(DATA_W)) u_cbu_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op_i),
    .rs_a_i     (rs_a_i),
    .rs_b_i     (rs_b_i),
    .flag_o     (flag_o),
    .br_taken_o (br_taken_o)
);

// File: tb/cmp_branch_unit_bench.sv
`timescale 1ns/100ps
module cmp_branch_unit_bench;

    localparam logic [3:0] C_NOP = 4'd0, C_ADD = 4'd1, C_SUB = 4'd2, C_EQ = 4'd3,
                           C_GE = 4'd4, C_GT = 4'd5, C_HS = 4'd6, C_HI = 4'd7,
                           C_PZ = 4'd8, C_BT = 4'd9, C_BF = 4'd10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op = C_NOP;
    logic [31:0] a = '0, b = '0, pc = '0;
    logic [7:0]  disp = '0;
    logic        flag, taken;
    logic [31:0] target;

    int  n_chk = 0, n_bad = 0;
    bit  model_flag = 1'b0;
    bit  done = 1'b0;

    always #2.5 clk = ~clk;

    cmp_branch_unit u_cmp_branch_unit (
        .clk(clk), .rst_n(rst_n), .op_i(op), .rs_a_i(a), .rs_b_i(b),
        .pc_i(pc), .disp_i(disp), .flag_o(flag), .br_taken_o(taken),
        .br_target_o(target)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic bit expect_cmp(logic [3:0] c, logic [31:0] x, logic [31:0] y,
                                      bit cur);
        case (c)
            C_EQ: return x == y;
            C_GE: return $signed(x) >= $signed(y);
            C_GT: return $signed(x) > $signed(y);
            C_HS: return x >= y;
            C_HI: return x > y;
            C_PZ: return $signed(x) >= 0;
            default: return cur;
        endcase
    endfunction

    // Issue one operation for one cycle and check taken, target and flag.
    task automatic run_op(string req, logic [3:0] c, logic [31:0] x, logic [31:0] y,
                          logic [31:0] p = 32'h100, logic [7:0] d = 8'h0);
        bit exp_t;
        @(negedge clk);
        op = c; a = x; b = y; pc = p; disp = d;
        #1;
        exp_t = (c == C_BT && model_flag) || (c == C_BF && !model_flag);
        check({req, " taken"}, {31'd0, taken}, {31'd0, exp_t});
        check({req, " target"}, target,
              p + 32'd4 + ({{24{d[7]}}, d} * 32'd2));
        @(posedge clk); #1;
        model_flag = expect_cmp(c, x, y, model_flag);
        check({req, " flag"}, {31'd0, flag}, {31'd0, model_flag});
    endtask

    task automatic t_reset_R1();
        rst_n = 1'b0; op = C_NOP;
        repeat (3) @(posedge clk);
        #1;
        check("R1 flag in reset", {31'd0, flag}, 32'd0);
        check("R1 taken in reset", {31'd0, taken}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        model_flag = 1'b0;
    endtask

    task automatic t_ge_R2();
        run_op("R2 ge equal", C_GE, 32'd5, 32'd5);
        run_op("R2 ge less", C_GE, 32'd4, 32'd5);
        run_op("R2 ge neg vs pos", C_GE, 32'hFFFF_FFFF, 32'd1);
        run_op("R2 ge pos vs neg", C_GE, 32'd1, 32'h8000_0000);
    endtask

    task automatic t_eq_R3();
        run_op("R3 eq same", C_EQ, 32'hDEAD_BEEF, 32'hDEAD_BEEF);
        run_op("R3 eq differ", C_EQ, 32'hDEAD_BEEF, 32'hDEAD_BEEE);
        run_op("R3 eq zero", C_EQ, 32'd0, 32'd0);
        run_op("R3 eq nonzero vs zero", C_EQ, 32'd1, 32'd0);
    endtask

    task automatic t_arith_R4();
        run_op("R4 set flag", C_EQ, 32'd7, 32'd7);
        run_op("R4 add keeps 1", C_ADD, 32'd0, 32'd0);
        run_op("R4 sub keeps 1", C_SUB, 32'd1, 32'd2);
        run_op("R4 clear flag", C_EQ, 32'd7, 32'd8);
        run_op("R4 add keeps 0", C_ADD, 32'd5, 32'd5);
    endtask

    task automatic t_branch_R5_R6_R11();
        run_op("R11 cmp true", C_EQ, 32'd3, 32'd3);
        run_op("R5 bt on set", C_BT, 0, 0);
        run_op("R6 bf on set", C_BF, 0, 0);
        run_op("R11 cmp false", C_GE, 32'd2, 32'd3);
        run_op("R5 bt on clear", C_BT, 0, 0);
        run_op("R6 bf on clear", C_BF, 0, 0);
    endtask

    task automatic t_gt_R7();
        run_op("R7 gt equal", C_GT, 32'd9, 32'd9);
        run_op("R7 gt greater", C_GT, 32'd10, 32'd9);
        run_op("R7 gt neg", C_GT, 32'hFFFF_FFF0, 32'd9);
    endtask

    task automatic t_unsigned_R8();
        run_op("R8 hs big unsigned", C_HS, 32'hFFFF_FFFF, 32'd1);
        run_op("R8 hs equal", C_HS, 32'd6, 32'd6);
        run_op("R8 hs lower", C_HS, 32'd1, 32'h8000_0000);
        run_op("R8 hi equal", C_HI, 32'd6, 32'd6);
        run_op("R8 hi higher", C_HI, 32'h8000_0000, 32'd1);
    endtask

    task automatic t_pz_R9();
        run_op("R9 pz zero", C_PZ, 32'd0, 32'h7FFF_FFFF);
        run_op("R9 pz negative", C_PZ, 32'h8000_0000, 32'h8000_0000);
        run_op("R9 pz positive b ignored", C_PZ, 32'd1, 32'hFFFF_FFFF);
    endtask

    task automatic t_target_R10();
        run_op("R10 max fwd", C_NOP, 0, 0, 32'h1000, 8'h7F);
        run_op("R10 max back", C_BT, 0, 0, 32'h1000, 8'h80);
        run_op("R10 wrap", C_BF, 0, 0, 32'hFFFF_FFFE, 8'h01);
    endtask

    task automatic t_other_R12();
        run_op("R12 set flag", C_HS, 32'd1, 32'd0);
        for (int c = 11; c < 16; c++)
            run_op("R12 unused code", 4'(c), 32'd0, 32'd9);
        run_op("R12 nop", C_NOP, 32'd0, 32'd9);
    endtask

    task automatic t_reset_mid_R1();
        run_op("R1 set before reset", C_EQ, 32'd1, 32'd1);
        t_reset_R1();
        run_op("R1 bf after reset", C_BF, 0, 0);
    endtask

    initial begin
        t_reset_R1();
        t_ge_R2();
        t_eq_R3();
        t_arith_R4();
        t_branch_R5_R6_R11();
        t_gt_R7();
        t_unsigned_R8();
        t_pz_R9();
        t_target_R10();
        t_other_R12();
        t_reset_mid_R1();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(5ns * 100000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule